// File: doc/BRIEF.md
# Prescaled 16-bit timer counter

This block is a free-running 16-bit up-counter whose advance rate is chosen from a 6-bit power-of-two divider of the bus clock or from rising edges on an external clock pin. Software reaches it over a small 8-bit register bus with three locations: a control register, a high count byte and a low count byte. The control register holds a halt bit, a self-clearing clear bit and a 3-bit rate select.

A 16-bit value cannot be read in one 8-bit access. To keep the two bytes consistent, reading the high byte freezes a copy of the low byte. The next low-byte read returns that copy and releases it. Everything runs in the bus clock domain. The external pin is brought in through a two-flop synchronizer followed by a rising-edge detector.

Read data is combinational from the address. Read side effects (latching, releasing) and writes take place at the rising clock edge on which `bus_rd_i` or `bus_wr_i` is high.

Top module: `pscnt_timer`

## Requirements
- R1: After reset the control register reads 0x00: not halted, rate select 0 (bus clock ÷1), and no low-byte copy pending.
- R2: Address 0 is the control register. Bit 7 is halt, bit 6 is clear and bits 2:0 are the rate select. Bits 6 to 3 always read 0, so the clear bit never reads back as 1.
- R3: With rate select k from 0 to 6, the counter advances once every 2^k bus clocks. The phase is measured from the edge at which the divider last restarted or was released from halt.
- R4: With rate select 7 the counter advances once for each rising edge of `ext_clk_i` seen through the two-flop synchronizer. With any other select the pin has no effect.
- R5: While halt is 1, neither the divider nor the counter advances. Edges on the external pin are dropped.
- R6: Writing the control register with bit 6 set zeroes the counter and the divider at that edge. Counting then resumes from 0x0000, and halt and select take the values written with it.
- R7: Writing halt and clear together in one write leaves the counter parked at 0x0000.
- R8: The counter wraps from 0xFFFF to 0x0000.
- R9: Reading address 1 returns count bits 15:8. If no copy is pending, the read also captures count bits 7:0 into the holding buffer.
- R10: Further reads of address 1 do not refresh a pending copy.
- R11: Reading address 2 returns the pending copy if there is one and releases it. With no copy pending, it returns the live count bits 7:0.
- R12: Addresses 1 and 2 are read-only, and writes to them are ignored. Address 3 reads 0. A clear write also drops any pending copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (read side effects) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |

## Verification
The bound checker examines several rules on every cycle:
- the count never moves while halted;
- the count steps by at most one per cycle, wrapping through 16 bits;
- a clear write zeroes the count, and a clear with halt parks it;
- the clear bit reads 0;
- a high-byte read captures the current low byte, and a pending copy stays fixed until a low-byte read releases it.

Only the bench scenarios can show the following:
- the exact division ratio of each select code;
- that each synchronized external edge is counted exactly once;
- the full wrap at 65536;
- that stale copies are returned after the live count has moved on.

// File: rtl/pscnt_pkg.sv
package pscnt_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_CNT_HI = 2'd1,
        ADDR_CNT_LO = 2'd2,
        ADDR_SPARE  = 2'd3
    } pscnt_addr_e;

    localparam int CTL_HALT_BIT = 7;
    localparam int CTL_CLR_BIT  = 6;

endpackage

// File: rtl/pscnt_prescale.sv
module pscnt_prescale #(
    parameter int DIV_W = 6,
    parameter int SEL_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             ext_i,
    output logic             tick_o
);

    localparam int EXT_CODE = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [1:0]       sync;
        logic             prev;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [DIV_W-1:0] tap_mask;
    logic             ext_rise;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], ext_i};
        st_d.prev = st_q.sync[1];
        if (restart_i) begin
            st_d.div = '0;
        end else if (run_i) begin
            st_d.div = st_q.div + DIV_W'(1);
        end

        for (int i = 0; i < DIV_W; i++) begin
            tap_mask[i] = (i < int'(sel_i));
        end

        ext_rise = st_q.sync[1] & ~st_q.prev;

        tick_o = 1'b0;
        if (run_i) begin
            if (int'(sel_i) == EXT_CODE) begin
                tick_o = ext_rise;
            end else if (int'(sel_i) <= DIV_W) begin
                tick_o = ((st_q.div & tap_mask) == tap_mask);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pscnt_count.sv
module pscnt_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        cnt_o = st_q.cnt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pscnt_regs.sv
module pscnt_regs
    import pscnt_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int SEL_W = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [1:0]         addr_i,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [BUS_W-1:0]   wdata_i,
    input  logic [2*BUS_W-1:0] cnt_i,
    output logic [BUS_W-1:0]   rdata_o,
    output logic               halt_o,
    output logic [SEL_W-1:0]   sel_o,
    output logic               clear_o,
    output logic               lat_pend_o,
    output logic [BUS_W-1:0]   lat_byte_o
);

    localparam int PAD_W = BUS_W - 2 - SEL_W;

    typedef struct packed {
        logic             halt;
        logic [SEL_W-1:0] sel;
        logic             lat_pend;
        logic [BUS_W-1:0] lat_byte;
    } reg_state_t;

    reg_state_t  st_d, st_q;
    pscnt_addr_e addr;
    logic        ctl_wr;
    logic        hi_rd;
    logic        lo_rd;
    logic        unused_wbits;

    assign unused_wbits = ^wdata_i[CTL_CLR_BIT-1:SEL_W];

    always_comb begin
        addr   = pscnt_addr_e'(addr_i);
        ctl_wr = wr_i && (addr == ADDR_CTRL);
        hi_rd  = rd_i && (addr == ADDR_CNT_HI);
        lo_rd  = rd_i && (addr == ADDR_CNT_LO);

        clear_o = ctl_wr && wdata_i[CTL_CLR_BIT];

        st_d = st_q;
        if (ctl_wr) begin
            st_d.halt = wdata_i[CTL_HALT_BIT];
            st_d.sel  = wdata_i[SEL_W-1:0];
        end
        if (clear_o) begin
            st_d.lat_pend = 1'b0;
        end else if (lo_rd) begin
            st_d.lat_pend = 1'b0;
        end else if (hi_rd && !st_q.lat_pend) begin
            st_d.lat_pend = 1'b1;
            st_d.lat_byte = cnt_i[BUS_W-1:0];
        end

        case (addr)
            ADDR_CTRL:   rdata_o = {st_q.halt, 1'b0, {PAD_W{1'b0}}, st_q.sel};
            ADDR_CNT_HI: rdata_o = cnt_i[2*BUS_W-1:BUS_W];
            ADDR_CNT_LO: rdata_o = st_q.lat_pend ? st_q.lat_byte : cnt_i[BUS_W-1:0];
            default:     rdata_o = '0;
        endcase

        halt_o     = st_q.halt;
        sel_o      = st_q.sel;
        lat_pend_o = st_q.lat_pend;
        lat_byte_o = st_q.lat_byte;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pscnt_timer.sv
module pscnt_timer #(
    parameter int BUS_W = 8,
    parameter int DIV_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ext_clk_i,
    input  logic [1:0]       bus_addr_i,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    input  logic [BUS_W-1:0] bus_wdata_i,
    output logic [BUS_W-1:0] bus_rdata_o
);

    localparam int CNT_W = 2 * BUS_W;
    localparam int SEL_W = $clog2(DIV_W + 2);

    logic             halt_w;
    logic [SEL_W-1:0] sel_w;
    logic             clear_w;
    logic             tick_w;
    logic [CNT_W-1:0] cnt_w;
    logic             lat_pend_w;
    logic [BUS_W-1:0] lat_byte_w;

    pscnt_regs #(
        .BUS_W(BUS_W),
        .SEL_W(SEL_W)
    ) regs_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .addr_i     (bus_addr_i),
        .wr_i       (bus_wr_i),
        .rd_i       (bus_rd_i),
        .wdata_i    (bus_wdata_i),
        .cnt_i      (cnt_w),
        .rdata_o    (bus_rdata_o),
        .halt_o     (halt_w),
        .sel_o      (sel_w),
        .clear_o    (clear_w),
        .lat_pend_o (lat_pend_w),
        .lat_byte_o (lat_byte_w)
    );

    pscnt_prescale #(
        .DIV_W(DIV_W),
        .SEL_W(SEL_W)
    ) pre_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (!halt_w),
        .restart_i (clear_w),
        .sel_i     (sel_w),
        .ext_i     (ext_clk_i),
        .tick_o    (tick_w)
    );

    pscnt_count #(
        .CNT_W(CNT_W)
    ) cnt_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_w),
        .clear_i (clear_w),
        .cnt_o   (cnt_w)
    );

endmodule

// File: rtl/pscnt_timer_chk.sv
module pscnt_timer_chk #(
    parameter int BUS_W = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [1:0]         bus_addr_i,
    input logic               bus_wr_i,
    input logic               bus_rd_i,
    input logic [BUS_W-1:0]   bus_wdata_i,
    input logic [BUS_W-1:0]   bus_rdata_o,
    input logic [2*BUS_W-1:0] cnt_w,
    input logic               halt_w,
    input logic               lat_pend_w,
    input logic [BUS_W-1:0]   lat_byte_w
);

    logic clr_wr, park_wr, hi_rd, lo_rd;

    assign clr_wr  = bus_wr_i && (bus_addr_i == 2'd0) && bus_wdata_i[6];
    assign park_wr = clr_wr && bus_wdata_i[7];
    assign hi_rd   = bus_rd_i && (bus_addr_i == 2'd1);
    assign lo_rd   = bus_rd_i && (bus_addr_i == 2'd2);

    AST_CLR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == 2'd0) |-> !bus_rdata_o[6]); // R2

    AST_STEP_AT_MOST_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!halt_w && !clr_wr) |=> (cnt_w == $past(cnt_w)) || (cnt_w == $past(cnt_w) + 16'd1)); // R3

    AST_HALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halt_w && !clr_wr) |=> $stable(cnt_w)); // R5

    AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_wr |=> (cnt_w == '0)); // R6

    AST_PARK_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        park_wr |=> halt_w && (cnt_w == '0)); // R7

    AST_WRAP_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!halt_w && !clr_wr && (cnt_w == 16'hFFFF)) |=> (cnt_w == 16'hFFFF) || (cnt_w == 16'h0000)); // R8

    AST_HI_CAPTURES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hi_rd && !lat_pend_w && !clr_wr) |=> lat_pend_w && (lat_byte_w == $past(cnt_w[BUS_W-1:0]))); // R9

    AST_COPY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lat_pend_w && !lo_rd && !clr_wr) |=> lat_pend_w && $stable(lat_byte_w)); // R10

    AST_LO_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lo_rd |=> !lat_pend_w); // R11

    AST_LO_RETURNS_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((bus_addr_i == 2'd2) && lat_pend_w) |-> (bus_rdata_o == lat_byte_w)); // R11

endmodule

bind pscnt_timer pscnt_timer_chk #(.BUS_W(BUS_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_addr_i  (bus_addr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .cnt_w       (cnt_w),
    .halt_w      (halt_w),
    .lat_pend_w  (lat_pend_w),
    .lat_byte_w  (lat_byte_w)
);

// File: tb/pscnt_timer_tb_top.sv
`timescale 1ns/1ps
module pscnt_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic [1:0] addr = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pscnt_timer dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ext_clk_i   (ext_clk),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        #1 wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(posedge clk);
        #1 rd = 1'b0;
    endtask

    task automatic rd_count(output int v);
        logic [7:0] hi, lo;
        rd_reg(2'd1, hi);
        rd_reg(2'd2, lo);
        v = {hi, lo};
    endtask

    // Park, release with select s, run m edges, halt, compare count to m / 2^s.
    task automatic t_divide(input int s, input int m, input string tag);
        int v;
        wr_reg(2'd0, 8'hC0 | 8'(s));
        wr_reg(2'd0, 8'(s));
        repeat (m - 1) @(posedge clk);
        wr_reg(2'd0, 8'h80 | 8'(s));
        rd_count(v);
        chk(tag, v, (m >> s) & 16'hFFFF);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd_reg(2'd0, d);
        chk("R1 control after reset", d, 8'h00);
    endtask

    task automatic t_ctrl_layout();
        logic [7:0] d;
        int v;
        wr_reg(2'd0, 8'hFD);
        rd_reg(2'd0, d);
        chk("R2 control readback clear and pad read zero", d, 8'h85);
        repeat (40) @(posedge clk);
        rd_count(v);
        chk("R7 halt with clear parks at zero", v, 0);
    endtask

    task automatic t_halt();
        int v;
        repeat (50) @(posedge clk);
        rd_count(v);
        chk("R5 count frozen while halted", v, 300);
    endtask

    task automatic t_latch();
        logic [7:0] d;
        wr_reg(2'd0, 8'h00);
        rd_reg(2'd1, d);
        chk("R9 high byte read", d, 8'h01);
        rd_reg(2'd1, d);
        chk("R10 second high read", d, 8'h01);
        repeat (20) @(posedge clk);
        rd_reg(2'd2, d);
        chk("R10 low returns first captured copy", d, 44);
        rd_reg(2'd2, d);
        chk("R11 low read with no copy is live", d, 67);
        wr_reg(2'd0, 8'h80);
        rd_reg(2'd1, d);
        wr_reg(2'd0, 8'hC0);
        rd_reg(2'd2, d);
        chk("R12 clear drops pending copy", d, 0);
        rd_reg(2'd0, d);
        chk("R6 control after clear write", d, 8'h80);
    endtask

    task automatic t_clear_running();
        int v;
        wr_reg(2'd0, 8'hC2);
        wr_reg(2'd0, 8'h02);
        repeat (49) @(posedge clk);
        wr_reg(2'd0, 8'h42);
        repeat (12) @(posedge clk);
        wr_reg(2'd0, 8'h82);
        rd_count(v);
        chk("R6 clear while running resumes from zero", v, 3);
    endtask

    task automatic t_ext();
        int v;
        wr_reg(2'd0, 8'hC7);
        wr_reg(2'd0, 8'h07);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) ext_clk = 1'b1;
            repeat (4) @(negedge clk);
            ext_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (6) @(posedge clk);
        wr_reg(2'd0, 8'h87);
        rd_count(v);
        chk("R4 one count per external rising edge", v, 5);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) ext_clk = 1'b1;
            repeat (4) @(negedge clk);
            ext_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (6) @(posedge clk);
        rd_count(v);
        chk("R5 external edges dropped while halted", v, 5);
        wr_reg(2'd0, 8'hC3);
        wr_reg(2'd0, 8'h03);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk) ext_clk = ~ext_clk;
        end
        wr_reg(2'd0, 8'h83);
        rd_count(v);
        chk("R4 external pin ignored with select 3", v, 5);
    endtask

    task automatic t_readonly();
        logic [7:0] d;
        int v;
        wr_reg(2'd1, 8'hAA);
        wr_reg(2'd2, 8'h55);
        rd_count(v);
        chk("R12 writes to count bytes ignored", v, 12);
        rd_reg(2'd3, d);
        chk("R12 spare address reads zero", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_layout();
        t_divide(0, 300, "R3 select 0 divides by 1");
        t_halt();
        t_latch();
        t_divide(1, 7, "R3 select 1 divides by 2");
        t_divide(2, 4, "R3 select 2 one full period");
        t_divide(6, 1000, "R3 select 6 divides by 64");
        t_divide(3, 100, "R3 select 3 divides by 8");
        t_readonly();
        t_clear_running();
        t_ext();
        t_divide(0, 65541, "R8 wrap past 0xFFFF");
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule